// File: doc/BRIEF.md
# Stream Filter Hot-Swap Handover Controller

This block replaces one streaming filter with another while the sample stream keeps flowing. It sits between one valid/ready input stream, two filter slots and the block's output. One slot is active and receives the stream. The other slot is empty and is the swap target. The controller runs the exchange in three phases. In the first, the new slot is prepared (its readiness arrives on an input) while the old filter keeps working unstalled. In the second, the old filter receives an end-of-stream marker and exports its internal state. In the third, that state is written into the new filter and the stream moves over to it.

An end-of-stream marker is a sideband bit on the slot-side stream; no data value is reserved for it. Input samples that arrive after the marker has been sent are parked in a 16-entry hold FIFO. They are replayed to the new filter ahead of any later input, so the stream loses, duplicates and reorders no sample. Each slot returns results on its own result port. A flag marks a word as exported state, and the last state word carries an end flag. Only sample results from the active slot reach the output.

Top module: `hsw_ctrl`

## Requirements
- R1: After reset slot 0 is active, slot 1 is marked empty (`slot_empty_o` = 2'b10) and `busy_o` is 0. While idle, input samples go straight to the active slot with that slot's ready as `in_ready_o`.
- R2: A `swap_req_i` pulse while not busy raises `busy_o` on the next cycle. Until the target slot reports ready, samples keep flowing to the old slot without a stall.
- R3: Only once the target slot's `slot_ready_i` bit is 1 does the old slot receive exactly one word with `s_eos_o` = 1. From then on input samples go to the hold FIFO.
- R4: The old slot's result words with the state flag set are captured in arrival order, up to 4 words, ending with the word whose end flag is set. State words never appear on `out_valid_o`.
- R5: The captured words are sent to the target slot in capture order with `s_state_o` = 1, before any sample reaches it.
- R6: When the last state word is accepted, the target slot becomes active and the old slot is marked empty. Held samples are then replayed in arrival order ahead of new input, so the output is the uninterrupted result of every accepted sample.
- R7: The hold FIFO takes 16 samples. When it is full, `in_ready_o` is 0 and no sample is lost.
- R8: A swap request while `busy_o` is 1 is ignored. `busy_o` stays 1 until the new slot is active and the hold FIFO has been replayed.
- R9: Only one slot sees `s_valid_o` at a time. The output follows the active slot and changes source only between whole result words, so results of samples the old slot took before the marker still reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swap_req_i | input | 1 | Start a swap to the empty slot |
| slot_ready_i | input | 2 | Per slot: module present and ready to take state |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DW | Input sample |
| in_ready_o | output | 1 | Input sample accepted |
| s_valid_o | output | 2 | Per slot: word presented to that slot |
| s_data_o | output | DW | Word to the slot (sample, state, or zero for marker) |
| s_eos_o | output | 1 | Word is the end-of-stream marker |
| s_state_o | output | 1 | Word is a state load word |
| s_ready_i | input | 2 | Per slot: slot accepts a word |
| r_valid_i | input | 2 | Per slot: result word valid |
| r_data_i | input | 2*DW | Result words, slot 1 in the upper half |
| r_state_i | input | 2 | Per slot: result word is exported state |
| r_eos_i | input | 2 | Per slot: last exported state word |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | DW | Output sample |
| busy_o | output | 1 | Swap in progress or backlog not replayed |
| active_o | output | 1 | Index of the active slot |
| slot_empty_o | output | 2 | Per slot: slot holds no live filter |

## Verification
Two functions can meet in one cycle. Live input can be pushed into the hold FIFO in the same cycle that the replay pops its head toward the newly active slot. The old slot can also still be returning results of earlier samples while the controller waits for its state words. The bench provokes both by streaming samples back to back through every phase of a swap, and once with the old slot's state export delayed long enough to fill the FIFO. It judges the outcome end to end. Its filter models keep a running sum and hand it over as state, so every output word must equal the running sum of all accepted samples, with no gap and no repeat.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_PRELOAD,
    ST_INJECT,
    ST_DRAIN,
    ST_LOAD
  } hsw_state_e;
endpackage

// File: rtl/hsw_fifo.sv
module hsw_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= data_i;
  end

  assign data_o  = mem[rp_q];
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hsw_state_buf.sv
module hsw_state_buf #(
  parameter int DW  = 16,
  parameter int NST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          adv_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_last_o
);
  localparam int IW = $clog2(NST + 1);
  localparam int AW = $clog2(NST);

  logic [DW-1:0] words_q [NST];
  logic [IW-1:0] wcnt_q, rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (clr_i) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      if (wr_i && wcnt_q < IW'(NST)) wcnt_q <= wcnt_q + 1'b1;
      if (adv_i) rcnt_q <= rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i && wcnt_q < IW'(NST)) words_q[wcnt_q[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = words_q[rcnt_q[AW-1:0]];
  assign rd_last_o = ((rcnt_q + IW'(1)) == wcnt_q);

  // R5
  rd_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (rcnt_q < wcnt_q));
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int DW         = 16,
  parameter int HOLD_DEPTH = 16,
  parameter int NST        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_req_i,
  input  logic [1:0]    slot_ready_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic [1:0]    s_valid_o,
  output logic [DW-1:0] s_data_o,
  output logic          s_eos_o,
  output logic          s_state_o,
  input  logic [1:0]    s_ready_i,
  input  logic [1:0]    r_valid_i,
  input  logic [2*DW-1:0] r_data_i,
  input  logic [1:0]    r_state_i,
  input  logic [1:0]    r_eos_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          busy_o,
  output logic          active_o,
  output logic [1:0]    slot_empty_o
);
  hsw_state_e state_q, state_d;
  logic       act_q, nxt;
  logic [1:0] empty_q;

  logic          f_push, f_pop, f_full, f_empty;
  logic [DW-1:0] f_data;
  logic          b_clr, b_wr, b_adv, b_last;
  logic [DW-1:0] b_data;
  logic          switch_now;

  assign nxt = ~act_q;

  hsw_fifo #(.DW(DW), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk_i, .rst_ni,
    .push_i (f_push), .data_i (in_data_i),
    .pop_i  (f_pop),  .data_o (f_data),
    .full_o (f_full), .empty_o(f_empty)
  );

  hsw_state_buf #(.DW(DW), .NST(NST)) u_sbuf (
    .clk_i, .rst_ni,
    .clr_i    (b_clr),
    .wr_i     (b_wr),
    .wr_data_i(act_q ? r_data_i[2*DW-1:DW] : r_data_i[DW-1:0]),
    .adv_i    (b_adv),
    .rd_data_o(b_data),
    .rd_last_o(b_last)
  );

  always_comb begin
    state_d    = state_q;
    s_valid_o  = '0;
    s_data_o   = in_data_i;
    s_eos_o    = 1'b0;
    s_state_o  = 1'b0;
    in_ready_o = 1'b0;
    f_push     = 1'b0;
    f_pop      = 1'b0;
    b_clr      = 1'b0;
    b_wr       = 1'b0;
    b_adv      = 1'b0;
    switch_now = 1'b0;
    // hold phases park input in the FIFO
    if (state_q inside {ST_INJECT, ST_DRAIN, ST_LOAD}) begin
      in_ready_o = !f_full;
      f_push     = in_valid_i && !f_full;
    end
    unique case (state_q)
      ST_RUN, ST_PRELOAD: begin
        if (f_empty) begin
          s_valid_o[act_q] = in_valid_i;
          in_ready_o       = s_ready_i[act_q];
        end else begin
          // replay backlog ahead of live input
          s_valid_o[act_q] = 1'b1;
          s_data_o         = f_data;
          f_pop            = s_ready_i[act_q];
          in_ready_o       = !f_full;
          f_push           = in_valid_i && !f_full;
        end
        if (state_q == ST_RUN) begin
          if (swap_req_i && f_empty) state_d = ST_PRELOAD;
        end else if (slot_ready_i[nxt]) begin
          state_d = ST_INJECT;
        end
      end
      ST_INJECT: begin
        s_valid_o[act_q] = 1'b1;
        s_eos_o          = 1'b1;
        s_data_o         = '0;
        b_clr            = 1'b1;
        if (s_ready_i[act_q]) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        b_wr = r_valid_i[act_q] && r_state_i[act_q];
        if (b_wr && r_eos_i[act_q]) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        s_valid_o[nxt] = 1'b1;
        s_state_o      = 1'b1;
        s_data_o       = b_data;
        if (s_ready_i[nxt]) begin
          b_adv = !b_last;
          if (b_last) begin
            switch_now = 1'b1;
            state_d    = ST_RUN;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      act_q   <= 1'b0;
      empty_q <= 2'b10;
    end else begin
      state_q <= state_d;
      if (switch_now) begin
        act_q   <= nxt;
        empty_q <= act_q ? 2'b10 : 2'b01;
      end
    end
  end

  assign out_valid_o  = r_valid_i[act_q] && !r_state_i[act_q];
  assign out_data_o   = act_q ? r_data_i[2*DW-1:DW] : r_data_i[DW-1:0];
  assign busy_o       = (state_q != ST_RUN) || !f_empty;
  assign active_o     = act_q;
  assign slot_empty_o = empty_q;

  // R3
  eos_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_eos_o && |s_valid_o) |-> slot_ready_i[~act_q]);
  // R9
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_valid_o));
  // R5
  load_to_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_state_o && |s_valid_o) |-> slot_empty_o[~act_q]);
  // R6
  one_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_empty_o) == 1);
  // R6
  switch_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(state_q) == ST_LOAD));
  // R8
  busy_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_LOAD) |=> $stable(act_q));
endmodule

// File: tb/hsw_slot_model.sv
module hsw_slot_model #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_eos_i,
  input  logic          s_state_i,
  input  logic [7:0]    emit_dly_i,
  output logic          r_valid_o,
  output logic [DW-1:0] r_data_o,
  output logic          r_state_o,
  output logic          r_eos_o,
  output int            eos_cnt_o,
  output int            ld_cnt_o
);
  logic [DW-1:0] acc, cnt;
  logic          pend, phase, ld_idx;
  logic [7:0]    dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0; cnt <= '0; pend <= 1'b0; phase <= 1'b0; ld_idx <= 1'b0; dly <= '0;
      r_valid_o <= 1'b0; r_data_o <= '0; r_state_o <= 1'b0; r_eos_o <= 1'b0;
      eos_cnt_o <= 0; ld_cnt_o <= 0;
    end else begin
      r_valid_o <= 1'b0;
      r_state_o <= 1'b0;
      r_eos_o   <= 1'b0;
      if (s_valid_i) begin
        if (s_eos_i) begin
          pend <= 1'b1; phase <= 1'b0; dly <= emit_dly_i;
          eos_cnt_o <= eos_cnt_o + 1;
        end else if (s_state_i) begin
          if (!ld_idx) acc <= s_data_i; else cnt <= s_data_i;
          ld_idx   <= ~ld_idx;
          ld_cnt_o <= ld_cnt_o + 1;
        end else begin
          acc <= acc + s_data_i;
          cnt <= cnt + 1'b1;
          r_valid_o <= 1'b1;
          r_data_o  <= acc + s_data_i;
        end
      end
      if (pend) begin
        if (dly != 0) dly <= dly - 1'b1;
        else begin
          r_valid_o <= 1'b1;
          r_state_o <= 1'b1;
          r_data_o  <= phase ? cnt : acc;
          r_eos_o   <= phase;
          phase     <= ~phase;
          if (phase) pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: tb/hsw_ctrl_tb.sv
module hsw_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap_req = 1'b0;
  logic [1:0] slot_ready = 2'b01;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready;
  logic [1:0] s_valid;
  logic [DW-1:0] s_data;
  logic s_eos, s_state;
  logic [1:0] r_valid, r_state, r_eos;
  logic [DW-1:0] r0_data, r1_data;
  logic out_valid, busy, active;
  logic [DW-1:0] out_data;
  logic [1:0] slot_empty;
  logic [7:0] dly0 = 8'd0, dly1 = 8'd0;
  int eos0, eos1, ld0, ld1;

  int tests = 0, fails = 0;
  int stalls = 0, early1 = 0;
  logic [DW-1:0] run_sum = '0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hsw_ctrl #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .swap_req_i(swap_req), .slot_ready_i(slot_ready),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .s_valid_o(s_valid), .s_data_o(s_data), .s_eos_o(s_eos), .s_state_o(s_state),
    .s_ready_i(2'b11), .r_valid_i(r_valid), .r_data_i({r1_data, r0_data}),
    .r_state_i(r_state), .r_eos_i(r_eos), .out_valid_o(out_valid), .out_data_o(out_data),
    .busy_o(busy), .active_o(active), .slot_empty_o(slot_empty)
  );

  hsw_slot_model #(.DW(DW)) u_slot0 (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid[0]), .s_data_i(s_data),
    .s_eos_i(s_eos), .s_state_i(s_state), .emit_dly_i(dly0),
    .r_valid_o(r_valid[0]), .r_data_o(r0_data), .r_state_o(r_state[0]),
    .r_eos_o(r_eos[0]), .eos_cnt_o(eos0), .ld_cnt_o(ld0)
  );

  hsw_slot_model #(.DW(DW)) u_slot1 (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid[1]), .s_data_i(s_data),
    .s_eos_i(s_eos), .s_state_i(s_state), .emit_dly_i(dly1),
    .r_valid_o(r_valid[1]), .r_data_o(r1_data), .r_state_o(r_state[1]),
    .r_eos_o(r_eos[1]), .eos_cnt_o(eos1), .ld_cnt_o(ld1)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) got_q.push_back(out_data);
    if (rst_n && s_valid[1] && !s_state && !s_eos && ld1 < 2) early1++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input int max_wait, output bit ok);
    int w;
    w = 0;
    in_valid = 1'b1;
    in_data  = d;
    #1;
    while (!in_ready && w < max_wait) begin
      @(negedge clk); #1;
      w++;
      stalls++;
    end
    ok = in_ready;
    if (ok) begin
      @(posedge clk);
      run_sum = run_sum + d;
      exp_q.push_back(run_sum);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stream(input int n, input int base);
    bit ok;
    for (int i = 0; i < n; i++) begin
      send(DW'(base + 3 * i), 1000, ok);
    end
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic wait_idle();
    int w;
    w = 0;
    while (busy && w < 500) begin
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic cmp_out(input string req);
    int bad;
    bad = 0;
    check(got_q.size() == exp_q.size(), req, "output count", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      if (got_q[i] != exp_q[i]) begin
        if (bad == 0) check(1'b0, req, "output word", int'(got_q[i]), int'(exp_q[i]));
        bad++;
      end
    end
    if (bad == 0) check(1'b1, req, "output words", 0, 0);
  endtask

  task automatic t_reset();
    #1;
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(active == 1'b0, "R1", "active after reset", active, 0);
    check(slot_empty == 2'b10, "R1", "empty after reset", slot_empty, 2);
    check(in_ready == 1'b1, "R1", "in_ready follows slot", in_ready, 1);
    check(out_valid == 1'b0, "R1", "no output after reset", out_valid, 0);
  endtask

  task automatic t_pass();
    stream(6, 5);
    repeat (3) @(negedge clk);
    cmp_out("R1");
  endtask

  task automatic t_swap_fwd();
    pulse_swap();
    #1;
    check(busy == 1'b1, "R2", "busy after request", busy, 1);
    stalls = 0;
    stream(8, 100);
    check(stalls == 0, "R2", "stalls while preloading", stalls, 0);
    check(eos0 == 0, "R3", "marker before slot ready", eos0, 0);
    slot_ready[1] = 1'b1;
    // second request during the swap must be ignored (R8)
    swap_req = 1'b1;
    stream(1, 200);
    swap_req = 1'b0;
    stream(12, 201);
    wait_idle();
    check(busy == 1'b0, "R8", "busy cleared", busy, 0);
    check(active == 1'b1, "R6", "new slot active", active, 1);
    check(slot_empty == 2'b01, "R6", "old slot empty", slot_empty, 1);
    check(eos0 == 1, "R3", "one marker to old slot", eos0, 1);
    check(eos1 == 0, "R8", "no marker to new slot", eos1, 0);
    check(ld1 == 2, "R5", "state words loaded", ld1, 2);
    check(early1 == 0, "R5", "samples before state", early1, 0);
    stream(5, 400);
    repeat (3) @(negedge clk);
    check(eos1 == 0, "R8", "ignored request left no swap", eos1, 0);
    cmp_out("R4");
  endtask

  task automatic t_fill();
    int acc_n, w;
    bit ok;
    slot_ready[0] = 1'b1;
    dly1 = 8'd40;
    pulse_swap();
    w = 0;
    while (eos1 == 0 && w < 50) begin
      @(negedge clk);
      w++;
    end
    check(eos1 == 1, "R3", "marker to old slot", eos1, 1);
    acc_n = 0;
    for (int i = 0; i < 20; i++) begin
      send(DW'(700 + i), 3, ok);
      if (!ok) break;
      acc_n++;
    end
    #1;
    check(acc_n == 16, "R7", "held samples", acc_n, 16);
    check(in_ready == 1'b0, "R7", "ready low when full", in_ready, 0);
    check(active == 1'b1, "R9", "old slot still active", active, 1);
    stream(6, 800);
    wait_idle();
    check(active == 1'b0, "R6", "back to slot 0", active, 0);
    check(slot_empty == 2'b10, "R6", "slot 1 empty", slot_empty, 2);
    check(ld0 == 2, "R5", "state into slot 0", ld0, 2);
    stream(4, 900);
    repeat (3) @(negedge clk);
    cmp_out("R7");
    cmp_out("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_swap_fwd();
    t_fill();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule